// File: doc/BRIEF.md
# Serial Port Register Decode and Interrupt Identification

This block is the host-facing register file of a 16550-style serial port. It sits on an 8-bit bus with a 3-bit offset and takes one read strobe and one write strobe. It holds the interrupt-enable, line-control, modem-control, FIFO-control, scratch and divisor registers. It builds the line-status and interrupt-identification words when they are read, and applies the side effects those reads carry.

The receive FIFO is outside the block. The block tells the FIFO when to push, pop and flush, and reads back whether the FIFO is empty or full, its head byte and an overrun pulse. Modem status also comes from outside: the block reports the input byte when that register is read and pulses a strobe so the external logic can clear its delta bits.

The transmitter is treated as always ready. A data write is sent out as a one-cycle byte strobe. In loopback mode the byte goes into the receive FIFO instead. The interrupt output is a level derived from the prioritised reason, so it follows every register access and every FIFO change.

Top module: `uart_regblock`

## Requirements
- R1: While LCR bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. In that state, a write to offset 0 sends no byte out.
- R2: After reset the divisor low byte reads 12 and the high byte reads 0. IER, LCR, MCR, SCR and FCR read or act as 0, and IIR reads 0x01.
- R3: IER (offset 1) stores only bits 3..0, and bits 7..4 always read 0. Bit 0 enables receive data, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R4: The IIR (offset 2 read) low nibble reports a fixed priority, highest first: 0x6 when overrun is set and enabled; 0xC when the FIFO holds data and receive is enabled; 0x2 when transmit-empty is pending and enabled; 0x0 when any of modem-status input bits 3..0 is set and modem is enabled; otherwise 0x1.
- R5: Every data-register write sets the transmit-empty pending flag. An IIR read that reports reason 0x2 clears it. An IIR read that reports any other reason leaves it set.
- R6: IIR bits 7..6 read 11 while FIFO mode is on, and 00 otherwise.
- R7: An FCR write (offset 2) with bit 0 clear stores 0. With bit 0 set, it stores only bits 7, 6, 3 and 0, which drive the trigger-level, DMA and FIFO-mode outputs. A flush pulse is issued when bit 0 changes, or when bits 0 and 1 are both written as 1.
- R8: An LSR read (offset 5) returns bit 6 and bit 5 set, bit 1 as the overrun flag and bit 0 as FIFO non-empty, then clears overrun. Writes to offset 5 are ignored.
- R9: A data read (offset 0, LCR bit 7 clear) returns the FIFO head and pops it. When the FIFO is empty it returns 0xFF and does not pop.
- R10: When MCR bit 4 (loopback) is set, data writes push into the receive FIFO and no byte goes out. A push attempted while the FIFO is full is dropped and sets overrun.
- R11: The interrupt output is high exactly when the IIR reason is not 0x1.
- R12: An overrun pulse that arrives in the same cycle as an LSR read is kept. The read shows the old flag, and the next read shows it set.
- R13: MCR (offset 4) stores bits 4..0 and reads 0 above them. An MSR read (offset 6) returns the modem-status input and pulses the MSR-read strobe. SCR (offset 7) reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irq | output | 1 | Level interrupt request |
| tx_stb | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| rx_push | output | 1 | Loopback push into receive FIFO |
| rx_push_data | output | 8 | Byte pushed in loopback |
| rx_pop | output | 1 | Pop receive FIFO head |
| rx_flush | output | 1 | Flush receive FIFO |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_full | input | 1 | Receive FIFO full |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_ovf | input | 1 | Receive overrun pulse |
| fifo_mode | output | 1 | FIFO mode enabled |
| dma_mode | output | 1 | DMA mode bit |
| rx_trig | output | 2 | Receive trigger level |
| msr_in | input | 8 | Modem status byte |
| msr_rd | output | 1 | MSR read strobe |
| mcr_out | output | 5 | Modem control bits |

## Verification
The collision of interest is an external overrun pulse landing in the same cycle as an LSR read, whose clear-on-read would otherwise erase the new event. The bench drives the overrun input together with the read strobe. It expects the read word to show the old flag, the following read to show bit 1 set, and the interrupt to be high with line status enabled in between. A loopback write into a full FIFO checks the same path from the write side, and chained IIR reads check that only a reported transmit-empty reason consumes its pending flag.

// File: rtl/uart_regblock.sv
module uart_regblock #(
  parameter logic [15:0] DIV_RESET = 16'd12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       tx_stb,
  output logic [7:0] tx_data,
  output logic       rx_push,
  output logic [7:0] rx_push_data,
  output logic       rx_pop,
  output logic       rx_flush,
  input  logic       rx_nonempty,
  input  logic       rx_full,
  input  logic [7:0] rx_data,
  input  logic       rx_ovf,
  output logic       fifo_mode,
  output logic       dma_mode,
  output logic [1:0] rx_trig,
  input  logic [7:0] msr_in,
  output logic       msr_rd,
  output logic [4:0] mcr_out
);

  localparam logic [3:0] WHY_LINE = 4'h6;
  localparam logic [3:0] WHY_RX   = 4'hC;
  localparam logic [3:0] WHY_TX   = 4'h2;
  localparam logic [3:0] WHY_MDM  = 4'h0;
  localparam logic [3:0] WHY_NONE = 4'h1;

  logic [7:0] div_lo_q, div_hi_q, lcr_q, fcr_q, scr_q;
  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic       ovr_q, txe_pend_q;
  logic [3:0] why;

  wire latch_sel = lcr_q[7];
  wire loop_on   = mcr_q[4];

  wire w_data = wr_en && addr == 3'd0 && !latch_sel;
  wire w_dlo  = wr_en && addr == 3'd0 &&  latch_sel;
  wire w_ier  = wr_en && addr == 3'd1 && !latch_sel;
  wire w_dhi  = wr_en && addr == 3'd1 &&  latch_sel;
  wire w_fcr  = wr_en && addr == 3'd2;
  wire w_lcr  = wr_en && addr == 3'd3;
  wire w_mcr  = wr_en && addr == 3'd4;
  wire w_scr  = wr_en && addr == 3'd7;
  wire r_data = rd_en && addr == 3'd0 && !latch_sel;
  wire r_iir  = rd_en && addr == 3'd2;
  wire r_lsr  = rd_en && addr == 3'd5;

  always_comb begin
    if (ovr_q && ier_q[2])                why = WHY_LINE;
    else if (rx_nonempty && ier_q[0])     why = WHY_RX;
    else if (txe_pend_q && ier_q[1])      why = WHY_TX;
    else if ((|msr_in[3:0]) && ier_q[3])  why = WHY_MDM;
    else                                  why = WHY_NONE;
  end

  assign irq = why != WHY_NONE;

  assign tx_stb       = w_data && !loop_on;
  assign tx_data      = wdata;
  assign rx_push      = w_data && loop_on && !rx_full;
  assign rx_push_data = wdata;
  assign rx_pop       = r_data && rx_nonempty;
  assign rx_flush     = w_fcr && ((wdata[0] != fcr_q[0]) || (wdata[0] && wdata[1]));
  assign msr_rd       = rd_en && addr == 3'd6;
  assign fifo_mode    = fcr_q[0];
  assign dma_mode     = fcr_q[3];
  assign rx_trig      = fcr_q[7:6];
  assign mcr_out      = mcr_q;

  always_comb begin
    case (addr)
      3'd0:    rdata = latch_sel ? div_lo_q : (rx_nonempty ? rx_data : 8'hFF);
      3'd1:    rdata = latch_sel ? div_hi_q : {4'h0, ier_q};
      3'd2:    rdata = {fcr_q[0] ? 2'b11 : 2'b00, 2'b00, why};
      3'd3:    rdata = lcr_q;
      3'd4:    rdata = {3'b000, mcr_q};
      3'd5:    rdata = {1'b0, 2'b11, 3'b000, ovr_q, rx_nonempty};
      3'd6:    rdata = msr_in;
      default: rdata = scr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q   <= DIV_RESET[7:0];
      div_hi_q   <= DIV_RESET[15:8];
      ier_q      <= '0;
      lcr_q      <= '0;
      mcr_q      <= '0;
      fcr_q      <= '0;
      scr_q      <= '0;
      ovr_q      <= 1'b0;
      txe_pend_q <= 1'b0;
    end else begin
      if (w_dlo) div_lo_q <= wdata;
      if (w_dhi) div_hi_q <= wdata;
      if (w_ier) ier_q    <= wdata[3:0];
      if (w_lcr) lcr_q    <= wdata;
      if (w_mcr) mcr_q    <= wdata[4:0];
      if (w_scr) scr_q    <= wdata;
      if (w_fcr) fcr_q    <= wdata[0] ? (wdata & 8'hC9) : 8'h00;
      if (rx_ovf || (w_data && loop_on && rx_full)) ovr_q <= 1'b1;
      else if (r_lsr)                               ovr_q <= 1'b0;
      if (w_data)                        txe_pend_q <= 1'b1;
      else if (r_iir && why == WHY_TX)   txe_pend_q <= 1'b0;
    end
  end

  AST_IER_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1 && !lcr_q[7]) |-> rdata[7:4] == 4'h0); // R3
  AST_TXE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !lcr_q[7]) |=> txe_pend_q); // R5
  AST_FLUSH_ON_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fcr_q[0]) |-> $past(rx_flush)); // R7
  AST_LSR_READY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5) |-> rdata[6:5] == 2'b11); // R8
  AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 4'h0) |-> !irq); // R11
  AST_OVR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> ovr_q); // R12

endmodule

// File: tb/uart_regblock_test.sv
module uart_regblock_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, rx_ovf = 1'b0;
  logic [7:0] wdata = '0, msr_in = '0;
  logic [7:0] rdata, tx_data, rx_push_data;
  logic irq, tx_stb, rx_push, rx_pop, rx_flush, fifo_mode, dma_mode, msr_rd;
  logic [1:0] rx_trig;
  logic [4:0] mcr_out;
  logic rx_nonempty, rx_full;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  int tx_cnt = 0, flush_cnt = 0, msr_cnt = 0;
  logic [7:0] tx_last = '0;

  logic [7:0] fq[$];
  int fcnt = 0;
  logic [7:0] fhead = '0;

  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  uart_regblock uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_stb(tx_stb), .tx_data(tx_data),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
    .rx_flush(rx_flush), .rx_nonempty(rx_nonempty), .rx_full(rx_full),
    .rx_data(rx_data), .rx_ovf(rx_ovf), .fifo_mode(fifo_mode),
    .dma_mode(dma_mode), .rx_trig(rx_trig), .msr_in(msr_in), .msr_rd(msr_rd),
    .mcr_out(mcr_out)
  );

  assign rx_nonempty = fcnt > 0;
  assign rx_full     = fcnt >= (fifo_mode ? 4 : 1);
  assign rx_data     = fhead;

  always @(posedge clk) begin
    if (tx_stb) begin tx_cnt++; tx_last = tx_data; end
    if (rx_flush) flush_cnt++;
    if (msr_rd) msr_cnt++;
    if (rx_flush) fq.delete();
    else begin
      if (rx_pop && fq.size() > 0) void'(fq.pop_front());
      if (rx_push) fq.push_back(rx_push_data);
    end
    fcnt  <= fq.size();
    fhead <= (fq.size() > 0) ? fq[0] : 8'h00;
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag, bit ovf = 1'b0);
    @(negedge clk);
    addr = a; rd_en = 1'b1; rx_ovf = ovf;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; rx_ovf = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_en) begin
        if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state, R9 empty data read
    rd(3'd1, 8'h00, "R2 IER reset");
    rd(3'd2, 8'h01, "R2 IIR reset");
    rd(3'd3, 8'h00, "R2 LCR reset");
    rd(3'd4, 8'h00, "R2 MCR reset");
    rd(3'd5, 8'h60, "R8 LSR empty");
    rd(3'd7, 8'h00, "R2 SCR reset");
    rd(3'd0, 8'hFF, "R9 empty data read");
    check("R11 irq at reset", irq, 0);
    // R1 divisor alias
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h0C, "R2 divisor low reset");
    rd(3'd1, 8'h00, "R2 divisor high reset");
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R1 divisor low");
    rd(3'd1, 8'h12, "R1 divisor high");
    check("R1 no byte out under latch", tx_cnt, 0);
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h03, "R1 LCR back");
    rd(3'd1, 8'h00, "R1 IER visible again");
    // R3 IER mask
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R3 IER mask");
    wr(3'd1, 8'h00);
    // R5 transmit pending
    wr(3'd0, 8'h41);
    check("R10 byte out count", tx_cnt, 1);
    check("R10 byte out value", tx_last, 8'h41);
    rd(3'd2, 8'h01, "R5 not reported while disabled");
    wr(3'd1, 8'h02);
    check("R11 irq on pending tx", irq, 1);
    rd(3'd2, 8'h02, "R5 reported");
    rd(3'd2, 8'h01, "R5 cleared by report");
    check("R11 irq drop", irq, 0);
    // R13 MCR mask, loopback
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h1F, "R13 MCR mask");
    check("R13 mcr_out", mcr_out, 5'h1F);
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'h55);
    check("R10 loopback sends nothing", tx_cnt, 1);
    rd(3'd2, 8'h0C, "R4 rx above tx");
    rd(3'd5, 8'h61, "R8 LSR data ready");
    wr(3'd0, 8'h66);
    rd(3'd2, 8'h06, "R4 line status top");
    rd(3'd5, 8'h63, "R10 overrun on full push");
    rd(3'd2, 8'h0C, "R8 overrun cleared by read");
    rd(3'd0, 8'h55, "R9 head byte");
    rd(3'd0, 8'hFF, "R9 empty after pop");
    msr_in = 8'h01;
    rd(3'd2, 8'h02, "R4 tx above modem");
    rd(3'd2, 8'h00, "R4 modem reason");
    check("R11 irq on modem", irq, 1);
    rd(3'd6, 8'h01, "R13 MSR read");
    check("R13 msr strobe", msr_cnt, 1);
    msr_in = 8'h00;
    rd(3'd2, 8'h01, "R4 nothing pending");
    wr(3'd4, 8'h00);
    // R6 R7 FIFO control
    wr(3'd2, 8'hC9);
    check("R7 flush on enable", flush_cnt, 1);
    check("R7 mode/dma/trig", {fifo_mode, dma_mode, rx_trig}, 4'b1111);
    rd(3'd2, 8'hC1, "R6 IIR fifo bits");
    wr(3'd2, 8'hCF);
    check("R7 flush on rx reset bit", flush_cnt, 2);
    wr(3'd2, 8'h01);
    check("R7 no flush steady", flush_cnt, 2);
    check("R7 masked store", {fifo_mode, dma_mode, rx_trig}, 4'b1000);
    wr(3'd2, 8'hC8);
    check("R7 flush on disable", flush_cnt, 3);
    check("R7 cleared store", {fifo_mode, dma_mode, rx_trig}, 4'b0000);
    rd(3'd2, 8'h01, "R6 IIR no fifo bits");
    // R8 write ignored, R13 scratch
    wr(3'd5, 8'hFF);
    rd(3'd5, 8'h60, "R8 LSR write ignored");
    wr(3'd7, 8'hA5);
    rd(3'd7, 8'hA5, "R13 scratch");
    // R12 overrun collides with LSR read
    rd(3'd5, 8'h60, "R12 read shows old flag", 1'b1);
    check("R12 irq after kept overrun", irq, 1);
    rd(3'd5, 8'h62, "R12 overrun kept");
    rd(3'd5, 8'h60, "R12 overrun then cleared");
    check("R11 irq low at end", irq, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule